// File: doc/BRIEF.md
# Boundary-Scan Test Program Sequencer

This block runs a byte-coded test program that is held in an external synchronous program memory. It drives one of several IEEE 1149.1 test access ports as bus master. It fetches one opcode at a time and generates TCK, TMS, TDI and an active-low TRST on the port that is currently selected. During a shift it reads TDO back and compares it, bit by bit, with expected values under a mask.

The data for a shift sits in program memory directly behind the shift opcode. It is grouped per byte as a triplet: a drive byte, then an expected byte, then a mask byte. Any masked mismatch sets a sticky error flag. A later jump instruction tests that flag, so a program can branch to its failure handling as soon as a fault is seen.

A host loads the program, pulses `start` and waits for `done`. Execution always begins at address 0 with port 0 selected and the error flag cleared.

Top module: `bscan_seq`

## Requirements
- R1: After reset, `busy`, `done` and `err` are low. A `start` pulse while not busy begins execution at address 0 and clears `err`. `busy` stays high until opcode 0xFF is executed; then `busy` is low and `done` is high.
- R2: Opcode 0x1A+p (for p < NPORT) selects port p, and port 0 is selected at every start. A port that is not selected holds TCK low, TMS high, TDI high and TRST_n high, and sees no TCK pulse.
- R3: Opcode 0x11 drives TRST_n of the selected port low for exactly TRST_CYC clock cycles, with no TCK pulse during that time.
- R4: Opcode 0x00 or 0x01 produces exactly one TCK pulse, with TMS equal to bit 0 of the opcode. TCK is low for TCK_HALF clock cycles and then high for TCK_HALF clock cycles.
- R5: Opcode 0x02 is followed by two bytes, high byte first, that load the 16-bit bit count. The count is not consumed by shifting, so it applies to every later shift until it is reloaded.
- R6: Opcode 0x05 shifts exactly `count` bits. It consumes 3*ceil(count/8) following bytes as (drive, expected, mask) triplets and uses each byte least significant bit first. The last triplet covers only the remaining bits. A count of 0 produces no TCK pulse and consumes no data bytes.
- R7: TDI and TMS never change while TCK is high. TDO is sampled when TCK rises. During a shift, TMS is low on every bit except the last one, where it is high.
- R8: A bit whose mask bit is 1 and whose TDO differs from its expected bit sets `err`. A mismatch with mask bit 0 has no effect. `err` stays set until the next start.
- R9: Opcode 0x06 is followed by a two-byte address, high byte first. It jumps to that address when `err` is set and otherwise continues with the byte after the address.
- R10: Every other opcode is a one-byte instruction with no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin program execution at address 0 |
| busy | output | 1 | Program is running |
| done | output | 1 | Stop opcode reached; held until the next start |
| err | output | 1 | Sticky masked-mismatch flag |
| mem_addr | output | 16 | Program memory read address |
| mem_rdata | input | 8 | Program memory data, valid one cycle after the address |
| tck_o | output | NPORT | Test clock, one per port |
| tms_o | output | NPORT | Test mode select, one per port |
| tdi_o | output | NPORT | Test data to the target, one per port |
| trst_n_o | output | NPORT | Active-low test reset, one per port |
| tdo_i | input | NPORT | Test data from the target, one per port |

## Verification
On every cycle, the embedded assertions check four things: at most one port pulses TCK, TCK never runs while idle or while TRST is asserted, TDI and TMS stay stable while TCK is high, and the error flag cannot drop during a run. Other behaviours can only be shown by the bench's programs run against a modelled target shift register. These are correct bit counts across byte boundaries, least-significant-first use of the inline triplets, the TMS rise on the final bit only, masked versus unmasked mismatches, the taken and not-taken jump, and the consumption of the right number of data bytes.

// File: rtl/bscan_seq.sv
module bscan_seq #(
  parameter int NPORT    = 2,
  parameter int TCK_HALF = 2,
  parameter int TRST_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [15:0]      mem_addr,
  input  logic [7:0]       mem_rdata,
  output logic [NPORT-1:0] tck_o,
  output logic [NPORT-1:0] tms_o,
  output logic [NPORT-1:0] tdi_o,
  output logic [NPORT-1:0] trst_n_o,
  input  logic [NPORT-1:0] tdo_i
);

  localparam int SW = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int HW = $clog2(TCK_HALF) + 1;
  localparam int TW = $clog2(TRST_CYC) + 1;
  localparam logic [HW-1:0] PH_END   = HW'(TCK_HALF - 1);
  localparam logic [TW-1:0] TRST_END = TW'(TRST_CYC - 1);

  localparam logic [7:0] OP_TMS0  = 8'h00;
  localparam logic [7:0] OP_TMS1  = 8'h01;
  localparam logic [7:0] OP_LDCNT = 8'h02;
  localparam logic [7:0] OP_SHIFT = 8'h05;
  localparam logic [7:0] OP_JERR  = 8'h06;
  localparam logic [7:0] OP_TRST  = 8'h11;
  localparam logic [7:0] OP_SEL   = 8'h1A;
  localparam logic [7:0] OP_STOP  = 8'hFF;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_OPND, S_DRV, S_EXP, S_MSK, S_LO, S_HI, S_TRST, S_DONE
  } state_t;

  state_t          st;
  logic            rd_ph;
  logic [15:0]     pc;
  logic [7:0]      op;
  logic [7:0]      opnd_hi;
  logic            opnd_idx;
  logic [15:0]     cnt;
  logic [15:0]     rem;
  logic [7:0]      drv_b, exp_b, msk_b;
  logic [2:0]      bit_i;
  logic            shifting;
  logic [HW-1:0]   ph;
  logic [TW-1:0]   trst_cnt;
  logic [SW-1:0]   sel;
  logic            tck_q, tms_q, tdi_q, trst_q, err_q;

  logic [7:0]      sel_off;
  logic            sel_hit;
  logic            tdo_sel;
  logic [2:0]      bit_nx;

  assign mem_addr = pc;
  assign busy     = (st != S_IDLE) && (st != S_DONE);
  assign done     = (st == S_DONE);
  assign err      = err_q;
  assign sel_off  = mem_rdata - OP_SEL;
  assign sel_hit  = sel_off < 8'(NPORT);
  assign tdo_sel  = tdo_i[sel];
  assign bit_nx   = bit_i + 3'd1;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign tck_o[p]    = (sel == SW'(p)) ? tck_q  : 1'b0;
    assign tms_o[p]    = (sel == SW'(p)) ? tms_q  : 1'b1;
    assign tdi_o[p]    = (sel == SW'(p)) ? tdi_q  : 1'b1;
    assign trst_n_o[p] = (sel == SW'(p)) ? trst_q : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  rd_ph <= 1'b0;  pc <= '0;  op <= '0;
      opnd_hi <= '0; opnd_idx <= 1'b0; cnt <= '0; rem <= '0;
      drv_b <= '0;   exp_b <= '0;   msk_b <= '0;  bit_i <= '0;
      shifting <= 1'b0; ph <= '0;   trst_cnt <= '0; sel <= '0;
      tck_q <= 1'b0; tms_q <= 1'b1; tdi_q <= 1'b1; trst_q <= 1'b1; err_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_DONE: begin
          if (start) begin
            pc <= '0; err_q <= 1'b0; rd_ph <= 1'b0; sel <= '0; st <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (!rd_ph) rd_ph <= 1'b1;
          else begin
            rd_ph <= 1'b0;
            pc    <= pc + 16'd1;
            op    <= mem_rdata;
            case (mem_rdata)
              OP_TMS0, OP_TMS1: begin
                tms_q <= mem_rdata[0]; shifting <= 1'b0; ph <= '0; st <= S_LO;
              end
              OP_LDCNT, OP_JERR: begin
                opnd_idx <= 1'b0; st <= S_OPND;
              end
              OP_SHIFT: begin
                if (cnt != '0) begin
                  rem <= cnt; bit_i <= '0; st <= S_DRV;
                end
              end
              OP_TRST: begin
                trst_q <= 1'b0; trst_cnt <= '0; st <= S_TRST;
              end
              OP_STOP: st <= S_DONE;
              default: if (sel_hit) sel <= sel_off[SW-1:0];
            endcase
          end
        end
        S_OPND: begin
          if (!rd_ph) rd_ph <= 1'b1;
          else begin
            rd_ph <= 1'b0;
            pc    <= pc + 16'd1;
            if (!opnd_idx) begin
              opnd_hi <= mem_rdata; opnd_idx <= 1'b1;
            end else begin
              if (op == OP_LDCNT) cnt <= {opnd_hi, mem_rdata};
              else if (err_q)     pc  <= {opnd_hi, mem_rdata};
              st <= S_FETCH;
            end
          end
        end
        S_DRV: begin
          if (!rd_ph) rd_ph <= 1'b1;
          else begin
            rd_ph <= 1'b0; pc <= pc + 16'd1; drv_b <= mem_rdata; st <= S_EXP;
          end
        end
        S_EXP: begin
          if (!rd_ph) rd_ph <= 1'b1;
          else begin
            rd_ph <= 1'b0; pc <= pc + 16'd1; exp_b <= mem_rdata; st <= S_MSK;
          end
        end
        S_MSK: begin
          if (!rd_ph) rd_ph <= 1'b1;
          else begin
            rd_ph <= 1'b0; pc <= pc + 16'd1; msk_b <= mem_rdata;
            tdi_q <= drv_b[0]; tms_q <= (rem == 16'd1);
            shifting <= 1'b1; ph <= '0; st <= S_LO;
          end
        end
        S_LO: begin
          if (ph == PH_END) begin
            ph <= '0; tck_q <= 1'b1; st <= S_HI;
            if (shifting && msk_b[bit_i] && (tdo_sel != exp_b[bit_i])) err_q <= 1'b1;
          end else ph <= ph + 1'b1;
        end
        S_HI: begin
          if (ph == PH_END) begin
            ph <= '0; tck_q <= 1'b0;
            if (!shifting) st <= S_FETCH;
            else begin
              rem <= rem - 16'd1;
              if (rem == 16'd1) st <= S_FETCH;
              else if (bit_i == 3'd7) begin
                bit_i <= '0; st <= S_DRV;
              end else begin
                bit_i <= bit_nx;
                tdi_q <= drv_b[bit_nx];
                tms_q <= (rem == 16'd2);
                st    <= S_LO;
              end
            end
          end else ph <= ph + 1'b1;
        end
        S_TRST: begin
          if (trst_cnt == TRST_END) begin
            trst_q <= 1'b1; st <= S_FETCH;
          end else trst_cnt <= trst_cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_one_tck_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tck_o));

  p_tck_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tck_q |-> busy);

  p_trst_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !trst_q |-> !tck_q);

  p_hold_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tck_q |-> ($stable(tdi_q) && $stable(tms_q)));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && err_q) |=> err_q);

endmodule

// File: tb/bscan_seq_test.sv
module bscan_seq_test;
  localparam int NPORT = 2, HALF = 2, TRC = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, err;
  logic [15:0] addr;
  logic [7:0]  rdata;
  logic [NPORT-1:0] tck, tms, tdi, trst_n, tdo;

  always #10 clk = ~clk;

  bscan_seq #(.NPORT(NPORT), .TCK_HALF(HALF), .TRST_CYC(TRC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
    .mem_addr(addr), .mem_rdata(rdata), .tck_o(tck), .tms_o(tms), .tdi_o(tdi),
    .trst_n_o(trst_n), .tdo_i(tdo));

  logic [7:0] mem [0:1023];
  always @(posedge clk) rdata <= mem[addr[9:0]];

  logic [63:0] tsr = '0, load_val = '0;
  logic ttdo = 1'b0, load_req = 1'b0, clr = 1'b0;
  logic tp0 = 1'b0, tp1 = 1'b0, tms_p = 1'b1, tdi_p = 1'b1;
  logic log_tms [0:255];
  logic log_tdi [0:255];
  int nr0 = 0, nr1 = 0, viol = 0, hi0 = 0, tlo0 = 0, tlo1 = 0;
  assign tdo = {1'b0, ttdo};

  always @(negedge clk) begin
    if (load_req) begin
      tsr <= load_val; ttdo <= load_val[0];
    end else begin
      if (tck[0] && !tp0) tsr <= {tdi[0], tsr[63:1]};
      if (!tck[0] && tp0) ttdo <= tsr[0];
    end
    if (clr) begin
      nr0 <= 0; nr1 <= 0; viol <= 0; hi0 <= 0; tlo0 <= 0; tlo1 <= 0;
    end else begin
      if (tck[0] && !tp0) begin
        log_tms[nr0[7:0]] <= tms[0]; log_tdi[nr0[7:0]] <= tdi[0]; nr0 <= nr0 + 1;
      end
      if (tck[1] && !tp1) nr1 <= nr1 + 1;
      if (tck[0] && tp0 && (tms[0] != tms_p || tdi[0] != tdi_p)) viol <= viol + 1;
      if (tck[0]) hi0 <= hi0 + 1;
      if (!trst_n[0]) tlo0 <= tlo0 + 1;
      if (!trst_n[1]) tlo1 <= tlo1 + 1;
    end
    tp0 <= tck[0]; tp1 <= tck[1]; tms_p <= tms[0]; tdi_p <= tdi[0];
  end

  int checks = 0, fails = 0, ptr = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic emit(input logic [7:0] b);
    mem[ptr] = b; ptr++;
  endtask

  task automatic new_prog();
    for (int i = 0; i < 1024; i++) mem[i] = 8'hFF;
    ptr = 0;
  endtask

  task automatic set_target(input logic [63:0] v);
    @(posedge clk); load_val <= v; load_req <= 1'b1;
    @(posedge clk); load_req <= 1'b0;
  endtask

  task automatic run();
    bit fin = 0;
    @(posedge clk); clr <= 1'b1;
    @(posedge clk); clr <= 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < 8000 && !fin; c++) begin
      @(negedge clk);
      if (done) fin = 1;
    end
    chk(fin, "R1 watchdog, program did not finish", 0, 1);
    repeat (2) @(negedge clk);
  endtask

  bit drv_a [0:63];
  bit exp_a [0:63];
  bit msk_a [0:63];

  task automatic emit_shift_data(input int n);
    for (int j = 0; j < (n + 7) / 8; j++) begin
      logic [7:0] d, e, m;
      d = '0; e = '0; m = '0;
      for (int b = 0; b < 8; b++)
        if (8 * j + b < n) begin
          d[b] = drv_a[8*j+b]; e[b] = exp_a[8*j+b]; m[b] = msk_a[8*j+b];
        end
      emit(d); emit(e); emit(m);
    end
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd4711);
    new_prog();
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 reset status", {busy, done}, 0);
    chk(err == 1'b0, "R1 reset err", err, 0);
    chk(tck == '0 && trst_n == 2'b11, "R2 reset pins", {tck, trst_n}, 3);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // reset sequence on port 0: R3, R4
    new_prog();
    emit(8'h1A); emit(8'h11);
    for (int i = 0; i < 5; i++) emit(8'h01);
    emit(8'h00); emit(8'hFF);
    run();
    chk(done && !busy, "R1 done after stop", {done, busy}, 2);
    chk(tlo0 == TRC, "R3 trst low cycles", tlo0, TRC);
    chk(tlo1 == 0, "R2 unselected trst", tlo1, 0);
    chk(nr0 == 6, "R4 tck pulses", nr0, 6);
    chk(nr1 == 0, "R2 unselected tck", nr1, 0);
    begin
      int bad = 0;
      for (int i = 0; i < 6; i++) if (log_tms[i] != (i < 5)) bad++;
      chk(bad == 0, "R4 tms per pulse", bad, 0);
    end
    chk(hi0 == 6 * HALF, "R4 tck high cycles", hi0, 6 * HALF);
    chk(tms[1] == 1'b1 && tdi[1] == 1'b1, "R2 unselected idle levels", {tms[1], tdi[1]}, 3);

    // unknown opcode skipped, port 1 select: R10, R2
    new_prog();
    emit(8'h77); emit(8'h1B); emit(8'h00); emit(8'h03); emit(8'h00); emit(8'hFF);
    run();
    chk(nr1 == 2, "R10 unknown opcodes skipped, port1 pulses", nr1, 2);
    chk(nr0 == 0, "R2 port0 quiet while port1 selected", nr0, 0);

    // zero count: R6
    new_prog();
    emit(8'h1A); emit(8'h02); emit(8'h00); emit(8'h00); emit(8'h05); emit(8'h01); emit(8'hFF);
    run();
    chk(nr0 == 1, "R6 zero count no shift", nr0, 1);
    chk(log_tms[0] == 1'b1, "R6 next byte is opcode", log_tms[0], 1);

    // count persists over two shifts: R5
    new_prog();
    emit(8'h02); emit(8'h00); emit(8'h05);
    emit(8'h05); emit(8'h15); emit(8'h00); emit(8'h00);
    emit(8'h05); emit(8'h0A); emit(8'h00); emit(8'h00);
    emit(8'hFF);
    run();
    chk(nr0 == 10, "R5 count reused", nr0, 10);
    begin
      int bad = 0;
      logic [9:0] want;
      want = {5'h0A, 5'h15};
      for (int i = 0; i < 10; i++) if (log_tdi[i] != want[i]) bad++;
      chk(bad == 0, "R5 tdi of both shifts", bad, 0);
    end
    chk(err == 1'b0, "R8 mask zero ignores mismatch", err, 0);

    // random shifts: R6 R7 R8 R9
    for (int it = 0; it < 15; it++) begin
      int n, kf, tgt;
      bit eexp;
      logic [63:0] v;
      case (it)
        0: n = 1;  1: n = 7;  2: n = 8;  3: n = 9;  4: n = 16;  5: n = 17;
        default: n = 1 + int'($urandom_range(39));
      endcase
      v = {$urandom(), $urandom()};
      kf = int'($urandom_range(n - 1));
      eexp = 0;
      for (int k = 0; k < n; k++) begin
        drv_a[k] = 1'($urandom());
        msk_a[k] = 1'($urandom());
        exp_a[k] = v[k];
        if (it % 3 == 1 && !msk_a[k] && $urandom_range(1) == 1) exp_a[k] = !v[k];
      end
      if (it % 3 == 2) begin
        msk_a[kf] = 1'b1; exp_a[kf] = !v[kf];
      end
      for (int k = 0; k < n; k++) if (msk_a[k] && exp_a[k] != v[k]) eexp = 1;
      set_target(v);
      new_prog();
      emit(8'h1A); emit(8'h02); emit(8'(n >> 8)); emit(8'(n));
      emit(8'h05);
      emit_shift_data(n);
      tgt = ptr + 4;
      emit(8'h06); emit(8'(tgt >> 8)); emit(8'(tgt)); emit(8'hFF);
      emit(8'h1B); emit(8'h01); emit(8'hFF);
      run();
      chk(nr0 == n, "R6 shifted bit count", nr0, n);
      begin
        int bt = 0, bm = 0;
        for (int k = 0; k < n; k++) begin
          if (log_tdi[k] != drv_a[k]) bt++;
          if (log_tms[k] != (k == n - 1)) bm++;
        end
        chk(bt == 0, "R6 tdi order lsb first", bt, 0);
        chk(bm == 0, "R7 tms high on last bit only", bm, 0);
      end
      chk(viol == 0, "R7 tdi/tms stable while tck high", viol, 0);
      chk(err == eexp, "R8 masked compare", err, eexp);
      chk(nr1 == (eexp ? 1 : 0), "R9 jump on error", nr1, eexp ? 1 : 0);
    end

    // sticky error across two shifts, then cleared by start: R8, R1
    set_target(64'h0);
    new_prog();
    emit(8'h02); emit(8'h00); emit(8'h04);
    emit(8'h05); emit(8'h00); emit(8'h01); emit(8'h01);
    emit(8'h05); emit(8'h00); emit(8'h00); emit(8'h0F);
    emit(8'h06); emit(8'h00); emit(8'h0F); emit(8'hFF);
    emit(8'h1B); emit(8'h01); emit(8'hFF);
    run();
    chk(err == 1'b1, "R8 err sticky over clean shift", err, 1);
    chk(nr1 == 1, "R9 jump taken", nr1, 1);
    new_prog();
    emit(8'h01); emit(8'hFF);
    run();
    chk(err == 1'b0, "R1 start clears err", err, 0);
    chk(nr0 == 1, "R2 start selects port 0", nr0, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL R1 global watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule